// File: doc/BRIEF.md
# Sorted Top-K Flow Table

This block keeps a small table of the heaviest network flows seen so far. Each cycle it may receive one flow tag together with a fresh frequency estimate for that flow. The table always holds its entries ordered from the largest estimate to the smallest. A tag that is already stored has its estimate overwritten, and the entry moves to its new rank. A tag that is not stored joins the table if there is a free slot. When the table is full, a new tag joins only if it beats the smallest stored estimate, and that smallest entry is then dropped.

Every slot owns a four-way multiplexer that picks its next contents: keep its value, take the incoming entry, or copy the slot above or below it. The choice depends on where the incoming tag was found and where its estimate ranks. The whole reorder therefore completes in one clock, with no serial walk, so updates can arrive back to back at full rate.

A read request copies the table into a snapshot shift register. The snapshot then streams out from rank 0 downward, one slot per cycle, while updates keep landing in the live table.

Top module: `topk_pq`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is low. A readout taken right after reset reports every slot with `rd_used` = 0.
- R2: The table stays sorted. Every used slot comes before every empty slot, and each used slot's estimate is at least the estimate of the used slot after it. The number of used slots never decreases.
- R3: An update whose tag is absent, applied while an empty slot exists, stores the entry behind every stored entry whose estimate is greater than or equal to it. Equal estimates therefore keep the older entry ahead.
- R4: With every slot used, an update whose tag is absent and whose estimate is less than or equal to the last slot's estimate leaves the table unchanged.
- R5: With every slot used, an update whose tag is absent and whose estimate exceeds the last slot's estimate drops the last slot's entry and stores the new one at its sorted rank.
- R6: An update whose tag is stored replaces that entry's estimate and moves it to its sorted rank among the others. The tag never appears twice, and the other entries keep their relative order.
- R7: While `upd_valid` is low, the table does not change, whatever `upd_tag` and `upd_est` carry.
- R8: A one-cycle `rd_req` makes `rd_valid` high starting the next cycle for exactly DEPTH consecutive cycles. Slots are presented from rank 0 to rank DEPTH-1 as {`rd_used`, `rd_tag`, `rd_est`}, and `rd_last` is high only with the final slot.
- R9: The streamed contents equal the table as it stood before the update presented in the same cycle as `rd_req`. Updates during the stream do not alter it, and an `rd_req` raised while a stream is running is ignored.
- R10: An update is accepted in every cycle in which `upd_valid` is high, including consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_tag | input | TAG_W | Flow tag of the update |
| upd_est | input | EST_W | Unsigned frequency estimate of the update |
| rd_req | input | 1 | Start a readout of the table |
| rd_valid | output | 1 | A readout slot is presented |
| rd_last | output | 1 | The presented slot is the last (rank DEPTH-1) |
| rd_used | output | 1 | The presented slot holds an entry |
| rd_tag | output | TAG_W | Tag of the presented slot |
| rd_est | output | EST_W | Estimate of the presented slot |

## Verification
The assertions take for granted that `upd_valid` is low while reset is applied. They also assume that estimates are compared as unsigned values, so a stored tag can be moved both up and down. Tag uniqueness is never assumed of the input, because the table itself guarantees it. The stimulus holds `upd_valid` low through each reset. It feeds tags that repeat on purpose, including an exact repeat of a stored pair, equal estimates and a decreasing estimate. It raises `rd_req` together with an update and again in the middle of a stream, so the ordering and snapshot properties are exercised at their edges.

// File: rtl/topk_pkg.sv
package topk_pkg;

  // Next-value choice of one table slot.
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_NEW   = 2'd1,
    SEL_ABOVE = 2'd2,
    SEL_BELOW = 2'd3
  } slot_sel_e;

endpackage

// File: rtl/topk_match.sv
module topk_match #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TAG_W-1:0]       key,
  input  logic [DEPTH-1:0]       slot_v,
  input  logic [DEPTH*TAG_W-1:0] tag_flat,
  output logic                   hit,
  output logic [IW-1:0]          hit_idx,
  output logic [DEPTH-1:0]       hit_oh
);

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      hit_oh[j] = slot_v[j] && (tag_flat[j*TAG_W +: TAG_W] == key);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (hit_oh[j]) hit_idx = IW'(j);
    end
  end

  assign hit = |hit_oh;

  // A stored tag may be present at most once (R6).
  p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh))
    else $error("duplicate tag in table");

endmodule

// File: rtl/topk_rank.sv
module topk_rank #(
  parameter int DEPTH = 8,
  parameter int EST_W = 32,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]       slot_v,
  input  logic [DEPTH*EST_W-1:0] est_flat,
  input  logic [DEPTH-1:0]       excl,
  input  logic [EST_W-1:0]       key_est,
  output logic [PW-1:0]          pos
);

  logic [DEPTH-1:0] ahead;

  // Entries with an estimate >= the key stay ahead of it (older wins ties).
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      ahead[j] = slot_v[j] && !excl[j] && (est_flat[j*EST_W +: EST_W] >= key_est);
    end
  end

  always_comb begin
    pos = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (ahead[j]) pos = pos + PW'(1);
    end
  end

endmodule

// File: rtl/topk_slot.sv
module topk_slot
  import topk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ENT_W = 49,
  parameter int J     = 0,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             hit,
  input  logic [IW-1:0]    hit_idx,
  input  logic [PW-1:0]    ins_pos,
  input  logic [ENT_W-1:0] new_ent,
  input  logic [ENT_W-1:0] above,
  input  logic [ENT_W-1:0] below,
  output logic [ENT_W-1:0] cur
);

  localparam logic [PW-1:0] J_P  = PW'(J);
  localparam logic [IW-1:0] J_I  = IW'(J);
  localparam logic [IW-1:0] JM_I = IW'((J > 0) ? J - 1 : 0);

  slot_sel_e        sel;
  logic [ENT_W-1:0] cur_d;

  // Slots ahead of the insertion point close the gap left by a hit entry;
  // slots behind it open a gap, unless the hit entry was above them.
  always_comb begin
    if (!upd_valid) begin
      sel = SEL_HOLD;
    end else if (J_P < ins_pos) begin
      sel = (hit && (J_I >= hit_idx)) ? SEL_BELOW : SEL_HOLD;
    end else if (J_P == ins_pos) begin
      sel = SEL_NEW;
    end else begin
      sel = (hit && (JM_I >= hit_idx)) ? SEL_HOLD : SEL_ABOVE;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_HOLD:  cur_d = cur;
      SEL_NEW:   cur_d = new_ent;
      SEL_ABOVE: cur_d = above;
      SEL_BELOW: cur_d = below;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur <= '0;
    else if (upd_valid) cur <= cur_d;
  end

endmodule

// File: rtl/topk_readout.sv
module topk_readout #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 49,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic [DEPTH*ENT_W-1:0] snap_in,
  output logic                   rd_valid,
  output logic                   rd_last,
  output logic [ENT_W-1:0]       rd_ent
);

  logic [DEPTH*ENT_W-1:0] sh_q, sh_d;
  logic [IW-1:0]          left_q, left_d;
  logic                   busy_q, busy_d;
  logic                   start;

  assign start = rd_req && !busy_q;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (start) begin
      sh_d   = snap_in;
      left_d = IW'(DEPTH - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      sh_d = {{ENT_W{1'b0}}, sh_q[DEPTH*ENT_W-1:ENT_W]};
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (start || busy_q) begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign rd_valid = busy_q;
  assign rd_last  = busy_q && (left_q == '0);
  assign rd_ent   = sh_q[ENT_W-1:0];

  p_stream_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid)
    else $error("stream cut short");
  p_stream_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_valid)
    else $error("stream overran");
  p_stream_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_req))
    else $error("stream started without request");

endmodule

// File: rtl/topk_pq.sv
module topk_pq #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16,
  parameter int EST_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [EST_W-1:0] upd_est,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic             rd_last,
  output logic             rd_used,
  output logic [TAG_W-1:0] rd_tag,
  output logic [EST_W-1:0] rd_est
);

  localparam int ENT_W = 1 + TAG_W + EST_W;
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = $clog2(DEPTH + 1);

  logic [1:0]             rst_pipe;
  logic                   rst_ni;
  logic [DEPTH*ENT_W-1:0] q_flat;
  logic [DEPTH-1:0]       q_v;
  logic [DEPTH*TAG_W-1:0] tag_flat;
  logic [DEPTH*EST_W-1:0] est_flat;
  logic                   hit;
  logic [IW-1:0]          hit_idx;
  logic [DEPTH-1:0]       hit_oh;
  logic [PW-1:0]          ins_pos;
  logic [ENT_W-1:0]       new_ent;
  logic [ENT_W-1:0]       rd_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign new_ent = {1'b1, upd_tag, upd_est};

  for (genvar j = 0; j < DEPTH; j++) begin : g_view
    assign q_v[j]                     = q_flat[j*ENT_W + ENT_W - 1];
    assign tag_flat[j*TAG_W +: TAG_W] = q_flat[j*ENT_W + EST_W +: TAG_W];
    assign est_flat[j*EST_W +: EST_W] = q_flat[j*ENT_W +: EST_W];
  end

  topk_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_ni),
    .key      (upd_tag),
    .slot_v   (q_v),
    .tag_flat (tag_flat),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_oh   (hit_oh)
  );

  topk_rank #(.DEPTH(DEPTH), .EST_W(EST_W)) u_rank (
    .slot_v   (q_v),
    .est_flat (est_flat),
    .excl     (hit_oh),
    .key_est  (upd_est),
    .pos      (ins_pos)
  );

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [ENT_W-1:0] above_w, below_w;
    if (j == 0) begin : g_top
      assign above_w = '0;
    end else begin : g_mid_a
      assign above_w = q_flat[(j-1)*ENT_W +: ENT_W];
    end
    if (j == DEPTH - 1) begin : g_bot
      assign below_w = '0;
    end else begin : g_mid_b
      assign below_w = q_flat[(j+1)*ENT_W +: ENT_W];
    end

    topk_slot #(.DEPTH(DEPTH), .ENT_W(ENT_W), .J(j)) u_slot (
      .clk       (clk),
      .rst_n     (rst_ni),
      .upd_valid (upd_valid),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .ins_pos   (ins_pos),
      .new_ent   (new_ent),
      .above     (above_w),
      .below     (below_w),
      .cur       (q_flat[j*ENT_W +: ENT_W])
    );

    if (j < DEPTH - 1) begin : g_order
      p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        q_v[j+1] |-> (q_v[j] && (est_flat[j*EST_W +: EST_W] >= est_flat[(j+1)*EST_W +: EST_W])))
        else $error("order broken at slot %0d", j);
    end
  end

  topk_readout #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rd_req   (rd_req),
    .snap_in  (q_flat),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .rd_ent   (rd_ent)
  );

  assign rd_used = rd_ent[ENT_W-1];
  assign rd_tag  = rd_ent[EST_W +: TAG_W];
  assign rd_est  = rd_ent[EST_W-1:0];

  p_used_grows_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ($countones(q_v) >= $past($countones(q_v))))
    else $error("used slot count dropped");
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_valid |=> $stable(q_flat))
    else $error("table changed without update");
  p_small_ignored_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && !hit && (&q_v) && (upd_est <= est_flat[(DEPTH-1)*EST_W +: EST_W]))
    |=> $stable(q_flat))
    else $error("small newcomer altered full table");
  p_new_head_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && (!q_v[0] || (upd_est > est_flat[EST_W-1:0])))
    |=> (q_v[0] && (tag_flat[TAG_W-1:0] == $past(upd_tag)) && (est_flat[EST_W-1:0] == $past(upd_est))))
    else $error("largest estimate not at head");

endmodule

// File: tb/sim_topk_pq.sv
module sim_topk_pq;

  localparam int DEPTH = 4;
  localparam int TAG_W = 8;
  localparam int EST_W = 16;
  localparam int NVEC  = 14;

  typedef struct packed {
    logic [7:0]  tag;
    logic [15:0] est;
    logic [7:0]  cnt;
  } vec_t;

  // Stimulus with expected used-slot count afterwards.
  localparam vec_t VEC [NVEC] = '{
    '{8'd10, 16'd5,  8'd1}, '{8'd20, 16'd9,  8'd2}, '{8'd30, 16'd5,  8'd3},
    '{8'd40, 16'd7,  8'd4}, '{8'd50, 16'd5,  8'd4}, '{8'd60, 16'd3,  8'd4},
    '{8'd10, 16'd12, 8'd4}, '{8'd70, 16'd6,  8'd4}, '{8'd30, 16'd6,  8'd4},
    '{8'd40, 16'd2,  8'd4}, '{8'd30, 16'd3,  8'd4}, '{8'd20, 16'd13, 8'd4},
    '{8'd30, 16'd3,  8'd4}, '{8'd80, 16'd20, 8'd4}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             upd_valid;
  logic [TAG_W-1:0] upd_tag;
  logic [EST_W-1:0] upd_est;
  logic             rd_req;
  logic             rd_valid, rd_last, rd_used;
  logic [TAG_W-1:0] rd_tag;
  logic [EST_W-1:0] rd_est;

  always #5 clk = ~clk;

  topk_pq #(.DEPTH(DEPTH), .TAG_W(TAG_W), .EST_W(EST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_tag(upd_tag),
    .upd_est(upd_est), .rd_req(rd_req), .rd_valid(rd_valid), .rd_last(rd_last),
    .rd_used(rd_used), .rd_tag(rd_tag), .rd_est(rd_est)
  );

  int checks = 0;
  int errors = 0;
  int seen_cnt;

  logic             mv [DEPTH];
  logic [TAG_W-1:0] mt [DEPTH];
  logic [EST_W-1:0] me [DEPTH];
  logic             ev [DEPTH];
  logic [TAG_W-1:0] et [DEPTH];
  logic [EST_W-1:0] ee [DEPTH];

  task automatic check(input bit ok, input string rq, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  task automatic model_clear();
    for (int j = 0; j < DEPTH; j++) begin
      mv[j] = 1'b0; mt[j] = '0; me[j] = '0;
    end
  endtask

  task automatic model_apply(input logic [TAG_W-1:0] t, input logic [EST_W-1:0] e);
    int h = -1;
    int n = 0;
    int p = 0;
    for (int j = 0; j < DEPTH; j++) if (mv[j] && mt[j] == t) h = j;
    if (h >= 0) begin
      for (int j = h; j < DEPTH - 1; j++) begin
        mv[j] = mv[j+1]; mt[j] = mt[j+1]; me[j] = me[j+1];
      end
      mv[DEPTH-1] = 1'b0;
    end else begin
      for (int j = 0; j < DEPTH; j++) if (mv[j]) n++;
      if (n == DEPTH) begin
        if (e <= me[DEPTH-1]) return;
        mv[DEPTH-1] = 1'b0;
      end
    end
    while (p < DEPTH && mv[p] && me[p] >= e) p++;
    for (int j = DEPTH - 1; j > p; j--) begin
      mv[j] = mv[j-1]; mt[j] = mt[j-1]; me[j] = me[j-1];
    end
    mv[p] = 1'b1; mt[p] = t; me[p] = e;
  endtask

  task automatic snap_model();
    for (int j = 0; j < DEPTH; j++) begin
      ev[j] = mv[j]; et[j] = mt[j]; ee[j] = me[j];
    end
  endtask

  // Compare the presented slot k with the expected snapshot.
  task automatic check_slot(input int k, input string rq);
    bit ok;
    ok = rd_valid && (rd_used == ev[k]) && (rd_last == (k == DEPTH - 1)) &&
         (!ev[k] || (rd_tag == et[k] && rd_est == ee[k]));
    check(ok, rq, $sformatf("slot %0d got v=%0b u=%0b l=%0b tag=%0d est=%0d exp u=%0b tag=%0d est=%0d",
          k, rd_valid, rd_used, rd_last, rd_tag, rd_est, ev[k], et[k], ee[k]));
    if (rd_used) seen_cnt++;
  endtask

  task automatic read_check(input string rq);
    snap_model();
    seen_cnt = 0;
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      check_slot(k, rq);
      @(negedge clk);
    end
    check(!rd_valid, "R8", $sformatf("rd_valid after stream got %0b exp 0", rd_valid));
  endtask

  task automatic upd(input logic [TAG_W-1:0] t, input logic [EST_W-1:0] e);
    @(negedge clk);
    upd_valid = 1'b1; upd_tag = t; upd_est = e;
    @(negedge clk);
    upd_valid = 1'b0;
    model_apply(t, e);
  endtask

  function automatic string vec_req(input int i);
    if (i == 4 || i == 5 || i == 8) return "R4";
    if (i == 6 || i == 9 || i == 11 || i == 12) return "R6";
    if (i == 7 || i == 10 || i == 13) return "R5";
    return "R3";
  endfunction

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_valid = 1'b0; upd_tag = '0; upd_est = '0; rd_req = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(!rd_valid, "R1", $sformatf("rd_valid in reset got %0b exp 0", rd_valid));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rd_valid, "R1", $sformatf("rd_valid after reset got %0b exp 0", rd_valid));
    read_check("R1");

    // Table walk: one update, then a full readout against the model.
    for (int i = 0; i < NVEC; i++) begin
      upd(VEC[i].tag, VEC[i].est);
      read_check(vec_req(i));
      check(seen_cnt == int'(VEC[i].cnt), "R2",
            $sformatf("vector %0d used count got %0d exp %0d", i, seen_cnt, VEC[i].cnt));
    end

    // R7: busy data lines with upd_valid low.
    @(negedge clk);
    upd_tag = 8'd99; upd_est = 16'd500;
    repeat (3) @(negedge clk);
    read_check("R7");

    // R10: updates on consecutive cycles.
    @(negedge clk) begin upd_valid = 1'b1; upd_tag = 8'd1;  upd_est = 16'd100; end
    @(negedge clk) begin upd_tag = 8'd2;  upd_est = 16'd50; end
    @(negedge clk) begin upd_tag = 8'd10; upd_est = 16'd1; end
    @(negedge clk) upd_valid = 1'b0;
    model_apply(8'd1, 16'd100);
    model_apply(8'd2, 16'd50);
    model_apply(8'd10, 16'd1);
    read_check("R10");

    // R9: request together with an update, then updates and a request mid-stream.
    snap_model();
    @(negedge clk) begin
      rd_req = 1'b1; upd_valid = 1'b1; upd_tag = 8'd3; upd_est = 16'd200;
    end
    @(negedge clk) begin rd_req = 1'b0; upd_valid = 1'b0; end
    model_apply(8'd3, 16'd200);
    seen_cnt = 0;
    for (int k = 0; k < DEPTH; k++) begin
      check_slot(k, "R9");
      if (k == 1) begin
        rd_req = 1'b1; upd_valid = 1'b1; upd_tag = 8'd4; upd_est = 16'd300;
        model_apply(8'd4, 16'd300);
      end
      @(negedge clk);
      rd_req = 1'b0; upd_valid = 1'b0;
    end
    check(!rd_valid, "R9", $sformatf("request during stream restarted it: rd_valid got %0b exp 0", rd_valid));
    read_check("R9");

    // R1: reset in the middle of operation empties the table.
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(!rd_valid, "R1", $sformatf("rd_valid in second reset got %0b exp 0", rd_valid));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
    read_check("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule